// File: doc/BRIEF.md
# Execute Packet Dispatcher

This block sits between program memory and eight functional units of a wide-issue processor core. Program memory delivers fetch packets of eight 32-bit instruction words. The dispatcher cuts the stream into execute packets and issues one execute packet per clock. Each issued instruction appears on the output lane of the functional unit that its unit-select field names.

Bit 0 of every instruction is a chain bit. A 1 means the following instruction joins the same execute packet. A 0 means the packet ends after this instruction. Execute packets may run across the boundary between two fetch packets, so no padding is needed. In that case the dispatcher parks the remainder and waits for the next fetch packet before it issues the joined packet. A new fetch packet is accepted only after the held one has been used up. A stall input freezes issue. If two instructions of one execute packet select the same unit, a conflict flag is raised.

Top module: `vliw_dispatch`

## Requirements
- R1: While reset is applied and right after it, `fetch_ready` is 1, and `issue_valid`, `unit_valid` and `conflict` are 0.
- R2: `fetch_ready` is 1 exactly when no fetch packet is held. After a packet is accepted, `fetch_ready` stays 0 until every instruction in that packet has been issued or parked.
- R3: Slot i of a fetch packet is `fetch_data[32*i+31:32*i]`, and slot 0 comes first. An instruction whose bit 0 is 1 is joined by the next one. A 0 in bit 0 closes the execute packet.
- R4: Each issue cycle emits exactly one whole execute packet, with at least one unit valid. Execute packets inside a held fetch packet issue in consecutive unstalled cycles.
- R5: Bits [3:1] of an instruction select its unit: 0..3 are L, S, M, D of side A, and 4..7 are L, S, M, D of side B. Unit u is flagged in `unit_valid[u]` and gets the word on `unit_instr[32*u+31:32*u]`.
- R6: A lane whose unit is not used in the issue cycle shows 0 on both its valid bit and its instruction lane. In a cycle with no issue, all lanes are 0.
- R7: When the chain of the held packet reaches slot 7 with its chain bit at 1, nothing issues in that cycle and the remainder is parked. After the next fetch packet is accepted, the first issue holds the parked instructions plus the leading slots of the new packet, up to and including the first chain bit of 0.
- R8: While `stall` is 1, nothing issues and the held position and parked instructions do not change. A fetch packet can still be accepted during a stall.
- R9: If two instructions of one execute packet select the same unit, including across a fetch boundary, `conflict` is 1 in that issue cycle. The lane then carries the instruction that comes later in program order.
- R10: `fetch_valid` and `fetch_data` are ignored while `fetch_ready` is 0. The held packet is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch packet is offered |
| fetch_data | input | 256 | Eight instruction slots, slot 0 in the low word |
| fetch_ready | output | 1 | Dispatcher can take a fetch packet |
| stall | input | 1 | Hold issue this cycle |
| issue_valid | output | 1 | An execute packet is issued this cycle |
| unit_valid | output | 8 | Per-unit issue flags |
| unit_instr | output | 256 | Per-unit instruction lanes, unit u in word u |
| conflict | output | 1 | Two instructions of the issued packet chose the same unit |

## Verification
A wrong held position would show up in the issue cycle that follows. The packet would contain the wrong slots or the wrong number of them, and this would be visible on `unit_valid` and the lanes at once. A lost or stale parked remainder only shows up on the first issue after the next fetch, as missing or extra lanes or a spurious conflict. A wrong held flag changes `fetch_ready` in the very next cycle: either a packet is refetched too early, or the block waits forever with no fetch. The bench runs a queue-based model beside the design and compares every output on every clock, so each of these faults is caught within a cycle of becoming visible.

// File: rtl/vliw_dispatch.sv
module vliw_dispatch #(
  parameter int SLOTS   = 8,
  parameter int IW      = 32,
  parameter int SEL_LSB = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [SLOTS*IW-1:0] fetch_data,
  output logic               fetch_ready,
  input  logic               stall,
  output logic               issue_valid,
  output logic [SLOTS-1:0]   unit_valid,
  output logic [SLOTS*IW-1:0] unit_instr,
  output logic               conflict
);
  localparam int PW = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [SLOTS-1:0][IW-1:0] slot_q, car_i_q, route_i;
  logic [SLOTS-1:0]         car_v_q, route_v, in_pkt;
  logic [PW-1:0]            pos_q, end_idx, last_idx;
  logic held_q, car_conf_q, end_found, route_conf, car_any, fire, park, take;

  assign car_any     = |car_v_q;
  assign fetch_ready = !held_q;
  assign take        = fetch_valid && fetch_ready;
  assign fire        = held_q && !stall && (end_found || car_any);
  assign park        = held_q && !stall && !end_found && !car_any;
  assign last_idx    = end_found ? end_idx : LAST;

  always_comb begin
    end_found = 1'b0;
    end_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (i >= int'(pos_q) && !slot_q[i][0]) begin
        end_found = 1'b1;
        end_idx   = PW'(i);
      end
    end
  end

  always_comb begin
    route_v    = car_v_q;
    route_i    = car_i_q;
    route_conf = car_conf_q;
    for (int i = 0; i < SLOTS; i++) begin
      in_pkt[i] = held_q && (i >= int'(pos_q)) && (!end_found || i <= int'(end_idx));
      if (in_pkt[i]) begin
        if (route_v[slot_q[i][SEL_LSB +: PW]]) route_conf = 1'b1;
        route_v[slot_q[i][SEL_LSB +: PW]] = 1'b1;
        route_i[slot_q[i][SEL_LSB +: PW]] = slot_q[i];
      end
    end
  end

  assign issue_valid = fire;
  assign unit_valid  = fire ? route_v : '0;
  assign conflict    = fire && route_conf;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    assign unit_instr[g*IW +: IW] = unit_valid[g] ? route_i[g] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      pos_q      <= '0;
      car_v_q    <= '0;
      car_conf_q <= 1'b0;
    end else if (take) begin
      held_q <= 1'b1;
      pos_q  <= '0;
    end else if (fire) begin
      car_v_q    <= '0;
      car_conf_q <= 1'b0;
      if (last_idx == LAST) held_q <= 1'b0;
      else pos_q <= last_idx + 1'b1;
    end else if (park) begin
      car_v_q    <= route_v;
      car_conf_q <= route_conf;
      held_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) slot_q <= fetch_data;
    if (park) car_i_q <= route_i;
  end

  // R4
  pkt_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> unit_valid != '0);

  // R9
  conflict_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> issue_valid);

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> !fetch_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !(fetch_valid && fetch_ready) |=> $stable(pos_q) && $stable(held_q) && $stable(car_v_q));

  // R7
  cross_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !stall && !issue_valid |=> fetch_ready);
endmodule

// File: tb/sim_vliw_dispatch.sv
module sim_vliw_dispatch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [255:0] fetch_data = '0;
  logic         fetch_ready;
  logic         stall = 1'b0;
  logic         issue_valid;
  logic [7:0]   unit_valid;
  logic [255:0] unit_instr;
  logic         conflict;

  int checks = 0;
  int errors = 0;
  int icnt = 0;
  bit done = 1'b0;
  string ph = "init";

  logic [31:0]  mq[$];
  logic [31:0]  mp[$];
  logic [31:0]  wq[$];
  logic [255:0] pend[$];

  always #5 clk = ~clk;

  vliw_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_ready(fetch_ready), .stall(stall), .issue_valid(issue_valid),
    .unit_valid(unit_valid), .unit_instr(unit_instr), .conflict(conflict)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] %s: actual %0h expected %0h", ph, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int unit, input bit ch);
    logic [31:0] r;
    r = $urandom();
    r[31] = 1'b1;
    return {r[31:4], unit[2:0], ch};
  endfunction

  task automatic word(input int unit, input bit ch);
    wq.push_back(mk(unit, ch));
  endtask

  task automatic flush();
    while (wq.size() >= 8) begin
      logic [255:0] p;
      for (int j = 0; j < 8; j++) p[j*32 +: 32] = wq[j];
      for (int j = 0; j < 8; j++) wq.delete(0);
      pend.push_back(p);
    end
  endtask

  task automatic step(input bit fv, input logic [255:0] fd, input bit st);
    int k, n;
    bit e_ready, e_issue, e_conf, park;
    logic [7:0] e_uv;
    logic [255:0] e_ui;
    logic [31:0] pk[$];
    fetch_valid = fv;
    fetch_data  = fd;
    stall       = st;
    #1;
    e_ready = (mq.size() == 0);
    e_issue = 0; e_conf = 0; park = 0; e_uv = '0; e_ui = '0; n = 0;
    if (!e_ready && !st) begin
      k = -1;
      foreach (mq[j]) if (k < 0 && mq[j][0] == 1'b0) k = j;
      if (k >= 0 || mp.size() > 0) begin
        e_issue = 1;
        n = (k >= 0) ? k + 1 : mq.size();
        pk = mp;
        for (int j = 0; j < n; j++) pk.push_back(mq[j]);
        foreach (pk[j]) begin
          int u = int'(pk[j][3:1]);
          if (e_uv[u]) e_conf = 1;
          e_uv[u] = 1'b1;
          e_ui[u*32 +: 32] = pk[j];
        end
      end else park = 1;
    end
    chk("R2 fetch_ready", 256'(fetch_ready), 256'(e_ready));
    chk("R4 issue_valid", 256'(issue_valid), 256'(e_issue));
    chk("R5 unit_valid", 256'(unit_valid), 256'(e_uv));
    chk("R6 unit_instr", unit_instr, e_ui);
    chk("R9 conflict", 256'(conflict), 256'(e_conf));
    if (issue_valid) icnt++;
    @(posedge clk);
    if (e_issue) begin
      for (int j = 0; j < n; j++) mq.delete(0);
      mp.delete();
    end
    if (park) begin
      mp = mq;
      mq.delete();
    end
    if (fv && e_ready) for (int j = 0; j < 8; j++) mq.push_back(fd[j*32 +: 32]);
    @(negedge clk);
  endtask

  task automatic run(input int stall_pct, input int gap_pct, input bit junk);
    int guard = 0;
    while ((pend.size() > 0 || mq.size() > 0 || mp.size() > 0) && guard < 20000) begin
      bit fv = 0;
      bit real_pkt = 0;
      bit st;
      logic [255:0] fd = '0;
      st = ($urandom_range(99) < stall_pct);
      if (mq.size() == 0 && pend.size() > 0 && $urandom_range(99) >= gap_pct) begin
        fv = 1; fd = pend[0]; real_pkt = 1;
      end else if (junk && mq.size() > 0) begin
        fv = 1; fd = {8{$urandom()}};
      end
      step(fv, fd, st);
      if (real_pkt) pend.delete(0);
      guard++;
    end
    step(0, '0, 0);
    step(0, '0, 0);
  endtask

  task automatic rand_stream(input int npk);
    int perm[8];
    repeat (npk) begin
      int sz = $urandom_range(8, 1);
      for (int j = 0; j < 8; j++) perm[j] = j;
      for (int j = 7; j > 0; j--) begin
        int r = $urandom_range(j, 0);
        int t = perm[j];
        perm[j] = perm[r];
        perm[r] = t;
      end
      for (int j = 0; j < sz; j++) word(perm[j], j != sz - 1);
    end
    while (wq.size() % 8 != 0) word(wq.size() % 8, 0);
    flush();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL [%s] watchdog: actual hung expected finish", ph);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ph = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fetch_ready in reset", 256'(fetch_ready), 256'(1));
    chk("R1 issue_valid in reset", 256'(issue_valid), 256'(0));
    chk("R1 unit_valid in reset", 256'(unit_valid), 256'(0));
    chk("R1 conflict in reset", 256'(conflict), 256'(0));
    rst_n = 1'b1;
    step(0, '0, 0);

    // R3: chain bits split one fetch packet into three execute packets
    ph = "R3 chain split";
    word(0, 1); word(1, 1); word(2, 0);
    word(4, 0);
    word(5, 1); word(6, 1); word(7, 1); word(3, 0);
    flush();
    icnt = 0;
    run(0, 0, 0);
    chk("R3 execute packet count", 256'(icnt), 256'(3));

    // R7: eight-wide packet whose first seven words sit at the end of a fetch packet
    ph = "R7 boundary crossing";
    word(0, 0);
    for (int j = 1; j < 8; j++) word(j, 1);
    word(0, 0);
    for (int j = 0; j < 7; j++) word(j, 0);
    flush();
    icnt = 0;
    run(0, 30, 0);
    chk("R7 execute packet count", 256'(icnt), 256'(9));

    // R9: duplicate unit inside one packet and across a boundary
    ph = "R9 unit conflict";
    word(2, 1); word(2, 0);
    for (int j = 0; j < 6; j++) word(j, 0);
    for (int j = 0; j < 6; j++) word(j, 0);
    word(3, 1); word(4, 1);
    word(3, 0);
    for (int j = 0; j < 7; j++) word(j, 0);
    flush();
    run(0, 0, 0);

    // R10: junk offered while a packet is held
    ph = "R10 ignored fetch";
    rand_stream(20);
    run(0, 0, 1);

    // R8: random stalls over a random stream
    ph = "R8 stall";
    rand_stream(60);
    run(35, 20, 1);

    ph = "R4 R5 R7 random";
    rand_stream(300);
    run(10, 10, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule